// File: doc/BRIEF.md
# Rolling-Shutter Correlated Double Sampling Row Sequencer

This block runs a frame-mode integrating pixel matrix one row at a time and digitises every column of the active row twice with a single-slope converter. For each row it selects the row and ramps once to capture the integrated level. It then holds the row reset high for a set number of cycles and ramps a second time to capture the reset-plus-offset level. After that it deselects the row and streams out the per-column difference, signal minus reset.

During both ramps a shared code counter is driven out, so an external ramp generator can follow it. Each column keeps the code of the first cycle in which its comparator input is high. The comparators, the ramp and the pixels themselves sit outside the block and appear only as the `cmpHit` inputs.

A start pulse launches a frame at row 0. A one-cycle frame-done pulse marks the end of the last row. In continuous mode the sequencer goes straight back to row 0. The default sizes are 128 rows, 128 columns and 8 bits. A row then takes SEL_CYCLES + 2·2^ADC_BITS + RST_CYCLES + NUM_COLS cycles, which is a relaxed version of a fixed 128-cycle row budget.

Top module: `rolling_cds_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, no row is selected, `rowRst`, `rampActive`, `diffValid` and `frameDone` are low.
- R2: A `startFrame` pulse while idle selects row 0 (`rowSel` = one-hot bit 0) in the next cycle, for SEL_CYCLES cycles before any ramp.
- R3: Each row follows this order with the row held selected throughout: select, then signal ramp (`rampPhase`=0, `rampCode` 0,1,…,2^ADC_BITS−1, one per cycle), then `rowRst` high for RST_CYCLES cycles with no ramp, then reset ramp (`rampPhase`=1, same code sequence), and finally deselect (`rowSel`=0).
- R4: `rowSel` has at most one bit set at any time, and `rowRst` is high only while a row is selected.
- R5: During a ramp, each column stores the `rampCode` of the first cycle in which its `cmpHit` bit is high. Later cycles with the bit high do not change the stored code.
- R6: A column whose `cmpHit` bit stays low for a whole ramp stores the full-scale code 2^ADC_BITS−1.
- R7: After the reset ramp, one column per cycle in ascending order 0..NUM_COLS−1, `diffValid` is high with `diffData` = signal code − reset code (two's complement, ADC_BITS+1 bits), `diffRow` = the row and `diffCol` = the column.
- R8: After the last row's output, `frameDone` is high for exactly one cycle. In that same cycle row 0 is already selected if `contMode` was high, and otherwise no row is selected and the block stays idle until the next start.
- R9: `startFrame` while a frame is in progress has no effect on the sequence or on the output data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startFrame | input | 1 | Launches a frame at row 0 when idle |
| contMode | input | 1 | Wrap to row 0 after the last row |
| cmpHit | input | NUM_COLS | Per-column comparator outputs, high once the ramp has crossed the pixel level |
| rowSel | output | NUM_ROWS | One-hot row select |
| rowRst | output | 1 | Row reset pulse |
| rampActive | output | 1 | A ramp conversion is running |
| rampPhase | output | 1 | 0 for the signal ramp, 1 for the reset ramp |
| rampCode | output | ADC_BITS | Shared ramp code counter |
| diffValid | output | 1 | Difference output valid |
| diffData | output | ADC_BITS+1 | Signed signal − reset value |
| diffRow | output | log2(NUM_ROWS) | Row index of the difference |
| diffCol | output | log2(NUM_COLS) | Column index of the difference |
| frameDone | output | 1 | One-cycle end-of-frame pulse |

## Verification
The hardest cases to reach from the ports are these:
- a comparator that rises at code 0 or at full scale;
- a comparator that never rises, in one ramp or in both;
- a restart request in the middle of a frame;
- the continuous-mode wrap.

The bench closes the loop by modelling each comparator from `rowSel`, `rampPhase` and `rampCode` against a per-pixel level table. That table includes extreme levels and never-fire flags, so the differences of −max, +max and zero from two silent ramps all appear. A scoreboard then checks every streamed difference while a second start pulse is injected mid-frame and continuous mode is switched off during the wrapped frame.

// File: rtl/rscds_pkg.sv
package rscds_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SELECT,
    ST_SIGRAMP,
    ST_RSTPULSE,
    ST_RSTRAMP,
    ST_DRAIN
  } seqState_t;

  // strobes from the sequencer to the column datapath
  typedef struct packed {
    logic clrSig;
    logic clrRst;
    logic capSig;
    logic capRst;
    logic emit;
  } dpStrobe_t;

  function automatic int maxOf4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/rscds_ctrl.sv
module rscds_ctrl
  import rscds_pkg::*;
#(
  parameter int NUM_ROWS   = 128,
  parameter int NUM_COLS   = 128,
  parameter int ADC_BITS   = 8,
  parameter int SEL_CYCLES = 2,
  parameter int RST_CYCLES = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        startFrame,
  input  logic                        contMode,
  output logic [NUM_ROWS-1:0]         rowSel,
  output logic                        rowRst,
  output logic                        rampActive,
  output logic                        rampPhase,
  output logic [ADC_BITS-1:0]         rampCode,
  output logic [$clog2(NUM_ROWS)-1:0] rowIdx,
  output logic [$clog2(NUM_COLS)-1:0] colIdx,
  output logic                        frameDone,
  output dpStrobe_t                   stb
);
  localparam int ROW_W     = $clog2(NUM_ROWS);
  localparam int COL_W     = $clog2(NUM_COLS);
  localparam int RAMP_LAST = (1 << ADC_BITS) - 1;
  localparam int CNT_W     = maxOf4(ADC_BITS, COL_W, $clog2(SEL_CYCLES + 1),
                                    $clog2(RST_CYCLES + 1)) + 1;

  seqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic             phaseLast;
  logic             lastRow;
  logic             inRow;

  always_comb begin
    case (state)
      ST_SELECT:   phaseLast = (cnt == CNT_W'(SEL_CYCLES - 1));
      ST_SIGRAMP,
      ST_RSTRAMP:  phaseLast = (cnt == CNT_W'(RAMP_LAST));
      ST_RSTPULSE: phaseLast = (cnt == CNT_W'(RST_CYCLES - 1));
      ST_DRAIN:    phaseLast = (cnt == CNT_W'(NUM_COLS - 1));
      default:     phaseLast = 1'b0;
    endcase
  end

  assign lastRow = (rowIdx == ROW_W'(NUM_ROWS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      rowIdx    <= '0;
      cnt       <= '0;
      frameDone <= 1'b0;
    end else begin
      frameDone <= 1'b0;
      if (state == ST_IDLE) begin
        if (startFrame) begin
          state  <= ST_SELECT;
          rowIdx <= '0;
          cnt    <= '0;
        end
      end else if (phaseLast) begin
        cnt <= '0;
        case (state)
          ST_SELECT:   state <= ST_SIGRAMP;
          ST_SIGRAMP:  state <= ST_RSTPULSE;
          ST_RSTPULSE: state <= ST_RSTRAMP;
          ST_RSTRAMP:  state <= ST_DRAIN;
          default: begin
            if (lastRow) begin
              frameDone <= 1'b1;
              rowIdx    <= '0;
              state     <= contMode ? ST_SELECT : ST_IDLE;
            end else begin
              rowIdx <= rowIdx + ROW_W'(1);
              state  <= ST_SELECT;
            end
          end
        endcase
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  assign inRow = (state == ST_SELECT) || (state == ST_SIGRAMP) ||
                 (state == ST_RSTPULSE) || (state == ST_RSTRAMP);

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_rowDec
    assign rowSel[r] = inRow && (rowIdx == ROW_W'(r));
  end

  assign rowRst     = (state == ST_RSTPULSE);
  assign rampActive = (state == ST_SIGRAMP) || (state == ST_RSTRAMP);
  assign rampPhase  = (state == ST_RSTRAMP);
  assign rampCode   = cnt[ADC_BITS-1:0];
  assign colIdx     = cnt[COL_W-1:0];

  assign stb.clrSig = (state == ST_SELECT) && phaseLast;
  assign stb.clrRst = (state == ST_RSTPULSE) && phaseLast;
  assign stb.capSig = (state == ST_SIGRAMP);
  assign stb.capRst = (state == ST_RSTRAMP);
  assign stb.emit   = (state == ST_DRAIN);

endmodule

// File: rtl/rscds_datapath.sv
module rscds_datapath
  import rscds_pkg::*;
#(
  parameter int NUM_ROWS = 128,
  parameter int NUM_COLS = 128,
  parameter int ADC_BITS = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dpStrobe_t                   stb,
  input  logic [NUM_COLS-1:0]         cmpHit,
  input  logic [ADC_BITS-1:0]         rampCode,
  input  logic [$clog2(NUM_ROWS)-1:0] rowIdx,
  input  logic [$clog2(NUM_COLS)-1:0] colIdx,
  output logic                        diffValid,
  output logic signed [ADC_BITS:0]    diffData,
  output logic [$clog2(NUM_ROWS)-1:0] diffRow,
  output logic [$clog2(NUM_COLS)-1:0] diffCol
);
  logic [ADC_BITS-1:0] sigVal [NUM_COLS];
  logic [ADC_BITS-1:0] rstVal [NUM_COLS];
  logic [NUM_COLS-1:0] sigHit;
  logic [NUM_COLS-1:0] rstHit;

  // first-crossing capture; a clear presets full scale for silent columns
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sigHit <= '0;
      rstHit <= '0;
      for (int c = 0; c < NUM_COLS; c++) begin
        sigVal[c] <= '0;
        rstVal[c] <= '0;
      end
    end else begin
      for (int c = 0; c < NUM_COLS; c++) begin
        if (stb.clrSig) begin
          sigVal[c] <= '1;
          sigHit[c] <= 1'b0;
        end else if (stb.capSig && cmpHit[c] && !sigHit[c]) begin
          sigVal[c] <= rampCode;
          sigHit[c] <= 1'b1;
        end
        if (stb.clrRst) begin
          rstVal[c] <= '1;
          rstHit[c] <= 1'b0;
        end else if (stb.capRst && cmpHit[c] && !rstHit[c]) begin
          rstVal[c] <= rampCode;
          rstHit[c] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      diffValid <= 1'b0;
      diffData  <= '0;
      diffRow   <= '0;
      diffCol   <= '0;
    end else begin
      diffValid <= stb.emit;
      if (stb.emit) begin
        diffData <= $signed({1'b0, sigVal[colIdx]}) - $signed({1'b0, rstVal[colIdx]});
        diffRow  <= rowIdx;
        diffCol  <= colIdx;
      end
    end
  end

endmodule

// File: rtl/rolling_cds_seq.sv
module rolling_cds_seq
  import rscds_pkg::*;
#(
  parameter int NUM_ROWS   = 128,
  parameter int NUM_COLS   = 128,
  parameter int ADC_BITS   = 8,
  parameter int SEL_CYCLES = 2,
  parameter int RST_CYCLES = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        startFrame,
  input  logic                        contMode,
  input  logic [NUM_COLS-1:0]         cmpHit,
  output logic [NUM_ROWS-1:0]         rowSel,
  output logic                        rowRst,
  output logic                        rampActive,
  output logic                        rampPhase,
  output logic [ADC_BITS-1:0]         rampCode,
  output logic                        diffValid,
  output logic signed [ADC_BITS:0]    diffData,
  output logic [$clog2(NUM_ROWS)-1:0] diffRow,
  output logic [$clog2(NUM_COLS)-1:0] diffCol,
  output logic                        frameDone
);
  localparam int ROW_W = $clog2(NUM_ROWS);
  localparam int COL_W = $clog2(NUM_COLS);

  dpStrobe_t        stb;
  logic [ROW_W-1:0] rowIdx;
  logic [COL_W-1:0] colIdx;

  rscds_ctrl #(
    .NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS), .ADC_BITS(ADC_BITS),
    .SEL_CYCLES(SEL_CYCLES), .RST_CYCLES(RST_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startFrame(startFrame), .contMode(contMode),
    .rowSel(rowSel), .rowRst(rowRst), .rampActive(rampActive),
    .rampPhase(rampPhase), .rampCode(rampCode), .rowIdx(rowIdx),
    .colIdx(colIdx), .frameDone(frameDone), .stb(stb)
  );

  rscds_datapath #(
    .NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS), .ADC_BITS(ADC_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cmpHit(cmpHit), .rampCode(rampCode),
    .rowIdx(rowIdx), .colIdx(colIdx), .diffValid(diffValid),
    .diffData(diffData), .diffRow(diffRow), .diffCol(diffCol)
  );

endmodule

// File: rtl/rscds_checker.sv
module rscds_checker #(
  parameter int NUM_ROWS = 128,
  parameter int NUM_COLS = 128,
  parameter int ADC_BITS = 8
) (
  input logic                        clk,
  input logic                        rstN,
  input logic [NUM_ROWS-1:0]         rowSel,
  input logic                        rowRst,
  input logic                        rampActive,
  input logic [ADC_BITS-1:0]         rampCode,
  input logic                        diffValid,
  input logic [$clog2(NUM_COLS)-1:0] diffCol,
  input logic                        frameDone
);
  p_onehot_sel_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rowSel));

  p_rst_needs_row_r4: assert property (@(posedge clk) disable iff (!rstN)
    rowRst |-> (rowSel != '0));

  p_rst_no_ramp_r3: assert property (@(posedge clk) disable iff (!rstN)
    rowRst |-> !rampActive);

  p_ramp_from_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rampActive) |-> (rampCode == '0));

  p_ramp_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rampActive && $past(rampActive)) |-> (rampCode == $past(rampCode) + ADC_BITS'(1)));

  p_out_after_ramp_r7: assert property (@(posedge clk) disable iff (!rstN)
    diffValid |-> !rampActive);

  p_col_ascend_r7: assert property (@(posedge clk) disable iff (!rstN)
    (diffValid && $past(diffValid)) |-> (diffCol == $past(diffCol) + 1'b1));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

endmodule

bind rolling_cds_seq rscds_checker #(
  .NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS), .ADC_BITS(ADC_BITS)
) u_chk (
  .clk(clk), .rstN(rstN), .rowSel(rowSel), .rowRst(rowRst),
  .rampActive(rampActive), .rampCode(rampCode), .diffValid(diffValid),
  .diffCol(diffCol), .frameDone(frameDone)
);

// File: tb/rolling_cds_seq_bench.sv
module rolling_cds_seq_bench;
  localparam int ROWS = 4;
  localparam int COLS = 4;
  localparam int BITS = 4;
  localparam int SELC = 2;
  localparam int RSTC = 3;
  localparam int FULL = (1 << BITS) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startFrame = 1'b0;
  logic contMode = 1'b0;
  logic [COLS-1:0] cmpHit;
  logic [ROWS-1:0] rowSel;
  logic rowRst, rampActive, rampPhase, diffValid, frameDone;
  logic [BITS-1:0] rampCode;
  logic signed [BITS:0] diffData;
  logic [$clog2(ROWS)-1:0] diffRow;
  logic [$clog2(COLS)-1:0] diffCol;

  always #4 clk = ~clk;

  rolling_cds_seq #(
    .NUM_ROWS(ROWS), .NUM_COLS(COLS), .ADC_BITS(BITS),
    .SEL_CYCLES(SELC), .RST_CYCLES(RSTC)
  ) u_rolling_cds_seq (
    .clk(clk), .rstN(rstN), .startFrame(startFrame), .contMode(contMode),
    .cmpHit(cmpHit), .rowSel(rowSel), .rowRst(rowRst), .rampActive(rampActive),
    .rampPhase(rampPhase), .rampCode(rampCode), .diffValid(diffValid),
    .diffData(diffData), .diffRow(diffRow), .diffCol(diffCol),
    .frameDone(frameDone)
  );

  int  sigL [ROWS][COLS];
  int  rstL [ROWS][COLS];
  bit  silS [ROWS][COLS];
  bit  silR [ROWS][COLS];

  typedef struct {
    int    row;
    int    col;
    int    val;
    string tag;
  } expItem_t;
  expItem_t expQ[$];

  int total = 0;
  int bad = 0;
  int doneCnt = 0;
  bit finished = 1'b0;

  // comparator model: high once the ramp reaches the pixel level
  always_comb begin
    int cur;
    cur = 0;
    cmpHit = '0;
    for (int r = 0; r < ROWS; r++) if (rowSel[r]) cur = r;
    for (int c = 0; c < COLS; c++) begin
      if (rampActive) begin
        if (rampPhase) cmpHit[c] = !silR[cur][c] && (int'(rampCode) >= rstL[cur][c]);
        else           cmpHit[c] = !silS[cur][c] && (int'(rampCode) >= sigL[cur][c]);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  // driver: set pixel levels and queue the expected differences
  task automatic loadFrame(input int seed, input int reps);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        sigL[r][c] = (r * 5 + c * 3 + seed * 7) % (FULL + 1);
        rstL[r][c] = (r * 3 + c * 11 + seed) % (FULL + 1);
        silS[r][c] = 1'b0;
        silR[r][c] = 1'b0;
      end
    if (seed == 0) begin
      sigL[0][0] = 0;    rstL[0][0] = FULL;
      sigL[0][1] = FULL; rstL[0][1] = 0;
      silS[0][2] = 1'b1; silR[0][2] = 1'b1;
      silS[0][3] = 1'b1; rstL[0][3] = 4;
      sigL[1][0] = 0;    rstL[1][0] = 0;
      silR[2][1] = 1'b1; sigL[2][1] = 9;
    end
    for (int k = 0; k < reps; k++)
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++) begin
          expItem_t e;
          int s, z;
          s = silS[r][c] ? FULL : sigL[r][c];
          z = silR[r][c] ? FULL : rstL[r][c];
          e.row = r; e.col = c; e.val = s - z;
          e.tag = (silS[r][c] || silR[r][c]) ? "R6" : "R5";
          expQ.push_back(e);
        end
  endtask

  // monitor: pop and compare each streamed difference
  always @(negedge clk) begin
    if (rstN && diffValid) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R7 unexpected output", int'(diffCol), -1);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        chk(int'(diffRow) == e.row && int'(diffCol) == e.col, "R7 row/col order",
            int'(diffRow) * 100 + int'(diffCol), e.row * 100 + e.col);
        chk(int'(diffData) == e.val, {e.tag, "/R7 difference"}, int'(diffData), e.val);
      end
    end
    if (rstN && frameDone) doneCnt++;
  end

  task automatic rowTiming(input int row);
    int n;
    bit codeOk;
    logic [ROWS-1:0] oh;
    oh = ROWS'(1) << row;
    while (rowSel == '0) @(negedge clk);
    chk(rowSel == oh, "R2 selected row", int'(rowSel), int'(oh));
    n = 0;
    while (rowSel == oh && !rampActive && !rowRst) begin n++; @(negedge clk); end
    chk(n == SELC, "R2 select length", n, SELC);
    n = 0; codeOk = 1'b1;
    while (rampActive && !rampPhase && rowSel == oh) begin
      if (int'(rampCode) != n) codeOk = 1'b0;
      n++; @(negedge clk);
    end
    chk(n == FULL + 1 && codeOk, "R3 signal ramp", n, FULL + 1);
    n = 0;
    while (rowRst && rowSel == oh && !rampActive) begin n++; @(negedge clk); end
    chk(n == RSTC, "R3 reset pulse", n, RSTC);
    n = 0; codeOk = 1'b1;
    while (rampActive && rampPhase && rowSel == oh) begin
      if (int'(rampCode) != n) codeOk = 1'b0;
      n++; @(negedge clk);
    end
    chk(n == FULL + 1 && codeOk, "R3 reset ramp", n, FULL + 1);
    chk(rowSel == '0, "R3 deselect", int'(rowSel), 0);
  endtask

  task automatic waitDone();
    int guard;
    guard = 0;
    while (!frameDone && guard < 5000) begin guard++; @(negedge clk); end
  endtask

  task automatic pulseStart();
    @(negedge clk) startFrame = 1'b1;
    @(negedge clk) startFrame = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog R8 actual=timeout expected=frame end");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int quiet;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rowSel == '0 && !rowRst && !rampActive && !diffValid && !frameDone,
        "R1 during reset", int'(rowSel), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(rowSel == '0 && !rowRst && !rampActive && !diffValid && !frameDone,
        "R1 after reset", int'(rowSel), 0);

    // single frame, corner levels
    loadFrame(0, 1);
    pulseStart();
    rowTiming(0);
    waitDone();
    chk(rowSel == '0, "R8 no wrap when contMode low", int'(rowSel), 0);
    @(negedge clk);
    chk(!frameDone, "R8 single-cycle pulse", int'(frameDone), 0);
    quiet = 1;
    repeat (60) begin
      if (rowSel != '0 || rampActive || diffValid) quiet = 0;
      @(negedge clk);
    end
    chk(quiet == 1, "R8 idle after frame", quiet, 1);

    // continuous mode with a stray start mid-frame (R9)
    loadFrame(1, 2);
    contMode = 1'b1;
    pulseStart();
    repeat (30) @(negedge clk);
    pulseStart();
    waitDone();
    chk(rowSel == ROWS'(1), "R8 wrap to row 0", int'(rowSel), 1);
    @(negedge clk) contMode = 1'b0;
    waitDone();
    chk(rowSel == '0, "R8 stop after contMode cleared", int'(rowSel), 0);
    repeat (5) @(negedge clk);
    chk(expQ.size() == 0, "R7 all differences delivered", expQ.size(), 0);
    chk(doneCnt == 3, "R9 frame count unchanged by stray start", doneCnt, 3);

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule